// File: doc/BRIEF.md
# Signed Integer and Float Format Bridge

This block moves sampled data between two number formats. One path takes an N-bit two's-complement word and treats it as a whole number, with the binary point just to the right of the lowest bit. It turns that word into a 32-bit float. The float has a sign bit in bit 31 and an 8-bit exponent in bits 30:23, stored with an offset of 128. Bits 22:0 hold the fraction below a hidden leading one, so a float stands for (1.fraction) x 2^(exponent-128). The other path takes such a float and turns it back into an N-bit signed integer.

The forward path takes the magnitude of the integer and finds its highest set bit. It then left-aligns the bits below that bit into the fraction field. The reverse path restores the hidden one and shifts the mantissa right by the exponent. It drops any fractional bits, which truncates toward zero, and reapplies the sign. Both paths are combinational. A parameter can add one register stage on the outputs. The width N may be any value from 2 to 23, so every integer in range has an exact float image.

Top module: `int_float_bridge`

## Requirements
- R1: An integer input of zero gives the float 32'h0000_0000.
- R2: The float sign bit (bit 31) is 1 exactly when the integer input is negative.
- R3: A nonzero integer with magnitude M, whose highest set bit is at position p, gives exponent bits 30:23 equal to 128+p. It gives fraction bits 22:0 equal to (M - 2^p) shifted left by 23-p.
- R4: For every N-bit integer, the float produced by the forward path is converted back to the same integer by the reverse path.
- R5: A float whose exponent field is below 128 (magnitude below one, including the all-zero float) gives the integer 0.
- R6: Reverse conversion truncates toward zero. For example, +2.75 gives 2 and -2.75 gives -2. No rounding is applied.
- R7: A float whose exponent field is 128+N-1 or more saturates. It gives 2^(N-1)-1 when bit 31 is 0 and -2^(N-1) when bit 31 is 1.
- R8: With REG_OUT=1, both outputs reflect the inputs one rising clock edge later, and an active-low reset clears both outputs to zero. With REG_OUT=0, the outputs are combinational.
- R9: The most negative integer -2^(N-1) gives sign 1, exponent 128+N-1 and fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| int_in | input | N | Signed integer to convert to float |
| flt_out | output | 32 | Float image of int_in |
| flt_in | input | 32 | Float to convert to a signed integer |
| int_out | output | N | Signed integer image of flt_in |

## Verification
The forward path is tried on several kinds of input, each of which exposes a different fault:
- zero, which has no leading one;
- plus and minus one, where the fraction is empty;
- powers of two, which test the exponent on its own;
- mixed bit patterns, which test fraction alignment;
- the two extreme codes, which test magnitude overflow.

The reverse path is tried on the following floats:
- exponents just below and at the offset of 128, which split the zero region from one;
- values with a fraction, which show truncation on both signs;
- exponents at and past the N-bit limit, which show saturation.

A sweep of integers across the whole range is fed through both paths. It ties the two directions together.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
   localparam int FLT_W    = 32;
   localparam int EXP_W    = 8;
   localparam int FRAC_W   = 23;
   localparam int MANT_W   = FRAC_W + 1;
   localparam int EXP_BIAS = 128;
   localparam int SH_W     = 5;

   typedef struct packed {
      logic              sign;
      logic [EXP_W-1:0]  expo;
      logic [FRAC_W-1:0] frac;
   } flt_t;
endpackage

// File: rtl/ifb_lead_one.sv
module ifb_lead_one #(
   parameter int W  = 16,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [PW-1:0] pos_o,
   output logic          found_o
);
   always_comb begin
      pos_o   = '0;
      found_o = 1'b0;
      for (int k = 0; k < W; k++) begin
         if (vec_i[k]) begin
            pos_o   = PW'(k);
            found_o = 1'b1;
         end
      end
   end

   always_comb begin
      if (found_o) AST_LEAD_BIT_SET: assert (vec_i[pos_o]); // R3
   end
endmodule

// File: rtl/ifb_int_to_flt.sv
module ifb_int_to_flt
   import ifb_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] int_i,
   output flt_t         flt_o
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [N-1:0]      mag;
   logic [PW-1:0]     lead_pos;
   logic              lead_found;
   logic [SH_W-1:0]   shamt;
   logic [MANT_W-1:0] mant_ext;

   assign mag = int_i[N-1] ? (~int_i + N'(1)) : int_i;

   ifb_lead_one #(.W(N)) i_lead (
      .vec_i   (mag),
      .pos_o   (lead_pos),
      .found_o (lead_found)
   );

   assign shamt    = SH_W'(FRAC_W - int'(lead_pos));
   assign mant_ext = MANT_W'(mag);

   always_comb begin
      if (lead_found) begin
         flt_o.sign = int_i[N-1];
         flt_o.expo = EXP_W'(EXP_BIAS + int'(lead_pos));
         flt_o.frac = FRAC_W'(mant_ext << shamt);
      end else begin
         flt_o = '0;
      end
   end

   always_comb begin
      if (int_i == '0) AST_ZERO_MAPS_ZERO: assert (flt_o == '0); // R1
      AST_SIGN_FOLLOWS: assert (flt_o.sign == int_i[N-1]); // R2
      if (int_i != '0)
         AST_EXP_IN_RANGE: assert (int'(flt_o.expo) >= EXP_BIAS && int'(flt_o.expo) < EXP_BIAS + N); // R3
   end
endmodule

// File: rtl/ifb_flt_to_int.sv
module ifb_flt_to_int
   import ifb_pkg::*;
#(
   parameter int N = 16
) (
   input  flt_t         flt_i,
   output logic [N-1:0] int_o
);
   localparam logic [N-1:0] POS_MAX = {1'b0, {(N-1){1'b1}}};
   localparam logic [N-1:0] NEG_MIN = {1'b1, {(N-1){1'b0}}};

   logic [EXP_W-1:0]  pwr;
   logic              below_one;
   logic              too_big;
   logic [SH_W-1:0]   shamt;
   logic [N-1:0]      mag;

   assign below_one = int'(flt_i.expo) < EXP_BIAS;
   assign pwr       = flt_i.expo - EXP_W'(EXP_BIAS);
   assign too_big   = !below_one && (int'(pwr) >= N - 1);
   assign shamt     = SH_W'(FRAC_W - int'(pwr));
   assign mag       = N'({1'b1, flt_i.frac} >> shamt);

   always_comb begin
      if (below_one)        int_o = '0;
      else if (too_big)     int_o = flt_i.sign ? NEG_MIN : POS_MAX;
      else if (flt_i.sign)  int_o = ~mag + N'(1);
      else                  int_o = mag;
   end

   always_comb begin
      if (int'(flt_i.expo) < EXP_BIAS) AST_SMALL_IS_ZERO: assert (int_o == '0); // R5
      if (int'(flt_i.expo) >= EXP_BIAS + N - 1)
         AST_SAT_BY_SIGN: assert (int_o == (flt_i.sign ? NEG_MIN : POS_MAX)); // R7
   end
endmodule

// File: rtl/ifb_out_stage.sv
module ifb_out_stage #(
   parameter int W   = 32,
   parameter bit REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
         end
      end else begin : g_wire
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/int_float_bridge.sv
module int_float_bridge
   import ifb_pkg::*;
#(
   parameter int N       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  int_in,
   output logic [31:0]   flt_out,
   input  logic [31:0]   flt_in,
   output logic [N-1:0]  int_out
);
   generate
      if (N < 2 || N > FRAC_W) begin : g_bad_width
         $error("int_float_bridge: N must lie in 2..23");
      end
   endgenerate

   flt_t         fwd_flt;
   logic [N-1:0] rev_int;

   ifb_int_to_flt #(.N(N)) i_fwd (
      .int_i (int_in),
      .flt_o (fwd_flt)
   );

   ifb_flt_to_int #(.N(N)) i_rev (
      .flt_i (flt_t'(flt_in)),
      .int_o (rev_int)
   );

   ifb_out_stage #(.W(FLT_W), .REG(REG_OUT)) i_flt_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (fwd_flt),
      .q_o   (flt_out)
   );

   ifb_out_stage #(.W(N), .REG(REG_OUT)) i_int_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rev_int),
      .q_o   (int_out)
   );

   generate
      if (REG_OUT) begin : g_chk_reg
         AST_SIGN_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (flt_out[31] == $past(int_in[N-1]))); // R8
      end
   endgenerate
endmodule

// File: tb/test_int_float_bridge.sv
module test_int_float_bridge;
   localparam int NB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] int_in = '0;
   logic [31:0]   flt_in = '0;
   logic [31:0]   flt_out;
   logic [NB-1:0] int_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0]   f;
      logic [NB-1:0] i;
      string         tag;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   int_float_bridge #(.N(NB), .REG_OUT(1'b1)) i_int_float_bridge (
      .clk     (clk),
      .rst_n   (rst_n),
      .int_in  (int_in),
      .flt_out (flt_out),
      .flt_in  (flt_in),
      .int_out (int_out)
   );

   function automatic logic [31:0] model_flt(int v);
      int m;
      int p;
      logic s;
      if (v == 0) return 32'h0;
      s = (v < 0);
      m = s ? -v : v;
      p = 0;
      for (int k = 0; k < 31; k++) if (m >= (1 << k)) p = k;
      return {s, 8'(128 + p), 23'((m - (1 << p)) << (23 - p))};
   endfunction

   function automatic int model_int(logic [31:0] f);
      int  e;
      real val;
      real lim;
      int  t;
      e = int'(f[30:23]);
      if (e < 128) return 0;
      val = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 128));
      lim = 2.0 ** (NB - 1);
      if (val >= lim) return f[31] ? -(1 << (NB - 1)) : (1 << (NB - 1)) - 1;
      t = $rtoi(val);
      return f[31] ? -t : t;
   endfunction

   function automatic logic [31:0] mkf(bit s, int e, int fr);
      return {s, 8'(e), 23'(fr)};
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic drive(int v, logic [31:0] f, string tag);
      item_t it;
      @(negedge clk);
      int_in = NB'(v);
      flt_in = f;
      it.f   = model_flt(v);
      it.i   = NB'(model_int(f));
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: one cycle after each drive, mid high phase
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(flt_out == it.f, it.tag, "flt_out", flt_out, it.f);
            check(int_out == it.i, it.tag, "int_out", 32'(int_out), 32'(it.i));
         end
      end
   end

   initial begin
      int_in = 16'h1234;
      flt_in = 32'h4200_0000;
      #15;
      check(flt_out == 32'h0, "R8", "reset flt_out", flt_out, 32'h0);
      check(int_out == '0, "R8", "reset int_out", 32'(int_out), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      drive(0, 32'h0, "R1 R5");
      drive(1, mkf(0, 128, 0), "R3");
      drive(-1, mkf(1, 128, 0), "R2");
      drive(5, mkf(0, 129, 23'h600000), "R6");
      drive(-7, mkf(1, 129, 23'h600000), "R2 R6");
      drive(256, mkf(0, 127, 23'h7fffff), "R3 R5");
      drive(16'h1234, mkf(1, 127, 0), "R3 R5");
      drive(32767, mkf(0, 143, 0), "R7");
      drive(-32768, mkf(1, 143, 0), "R9 R7");
      drive(-300, mkf(0, 200, 23'h123456), "R7");
      drive(1024, mkf(1, 255, 23'h7fffff), "R7");
      drive(-12345, mkf(0, 142, 23'h7fffff), "R6");
      drive(-2, mkf(1, 142, 23'h7fffff), "R6");
      drive(3, mkf(0, 0, 23'h400000), "R5");
      for (int v = -32768; v < 32768; v += 331)
         drive(v, model_flt(v), "R4");
      drive(32767, model_flt(32767), "R4");
      drive(-32768, model_flt(-32768), "R4 R9");

      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog timeout actual=%0d expected=0", sb.size());
         summary();
         $finish;
      end
   end
endmodule